// File: doc/BRIEF.md
# Partitioned Byte-by-Halfword Multiplier

This block multiplies unsigned 8-bit pixel components by signed 16-bit factors in four parallel lanes. Each lane keeps the middle sixteen bits of its product and rounds on the bit just below them. A 3-bit opcode selects one of seven variants. The variants differ in where the multiplicand byte and the factor are taken from, and in where each rounded lane result lands in the 64-bit output.

Operands enter through a valid/ready stream. The result leaves through a second valid/ready stream one register stage later.

Back-pressure rules:
- `in_ready` is high when the output register is empty, or when the consumer takes its content in the same cycle.
- While `out_valid` is high and `out_ready` is low, the output data is held unchanged and no new operand is accepted.

Fetching operands from register files is left to the surrounding datapath.

Top module: `pbm_mul`

## Requirements
- R1: Each lane forms the signed product of a zero-extended 8-bit multiplicand and a signed 16-bit factor. The lane result is product bits [23:8] plus one when product bit 7 is set.
- R2: The rounding increment wraps within 16 bits and never saturates. Multiplicand 1 with factor -128 gives lane result 0x0000.
- R3: Opcode 0 (lane-wise): byte i of `in_src1[31:0]` times signed halfword i of `in_src2`, result into halfword i, for i = 0..3.
- R4: Opcodes 1 and 2 (shared factor): byte i of `in_src1[31:0]` times one factor for all lanes, result into halfword i. The factor is `in_src2[31:16]` for opcode 1 and `in_src2[15:0]` for opcode 2.
- R5: Opcodes 3 and 4 (byte select): the multiplicand of lane i is `in_src1[16i+15:16i+8]` for opcode 3 and `in_src1[16i+7:16i]` for opcode 4. The factor is halfword i of `in_src2`, and the result goes into halfword i.
- R6: Opcodes 5 (upper byte) and 6 (lower byte) widen. Only lanes 0 and 1 are computed, with operands chosen as in R5. Lane i result goes to `out_data[32i+22:32i+7]`, and every other output bit is 0.
- R7: Opcode 7 produces an all-zero result.
- R8: An operand accepted at a clock edge (`in_valid` and `in_ready` high) appears on `out_data` with `out_valid` high right after that edge. With no new accept and the output consumed, `out_valid` falls after the next edge.
- R9: While `out_valid` is high and `out_ready` is low, `in_ready` is low and `out_data` stays unchanged.
- R10: After reset, `out_valid` is low and `in_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Operand set offered |
| in_ready | output | 1 | Operand set can be taken |
| in_op | input | 3 | Variant select, encoding in R3 to R7 |
| in_src1 | input | 64 | Multiplicand source |
| in_src2 | input | 64 | Factor source |
| out_valid | output | 1 | Result held in the output register |
| out_ready | input | 1 | Consumer takes the result |
| out_data | output | 64 | Packed lane results |

## Verification
A wrong operand steering or packing decision shows up as a wrong halfword on `out_data` in the cycle right after the accept, because only one register stands between the inputs and the ports. A rounding fault shows up only when product bit 7 is set, so every variant is driven with such products. The products at the range limits are covered too: 255 times -32768 and 255 times +32767. A fault in the valid or ready state shows within one cycle of a stall, as changed data or a lost or doubled result.

// File: rtl/pbm_pkg.sv
package pbm_pkg;
  localparam int BYTE_W = 8;
  localparam int HALF_W = 16;
  localparam int LANES  = 4;
  localparam int DATA_W = 64;
  localparam int OP_W   = 3;

  typedef enum logic [OP_W-1:0] {
    OP_FULL    = 3'd0,
    OP_SCAL_HI = 3'd1,
    OP_SCAL_LO = 3'd2,
    OP_BSEL_HI = 3'd3,
    OP_BSEL_LO = 3'd4,
    OP_WIDE_HI = 3'd5,
    OP_WIDE_LO = 3'd6,
    OP_NONE    = 3'd7
  } pbm_op_e;
endpackage

// File: rtl/pbm_lane.sv
module pbm_lane #(
  parameter int A_W = 8,
  parameter int B_W = 16
) (
  input  logic [A_W-1:0] a,
  input  logic [B_W-1:0] b,
  output logic [B_W-1:0] r
);
  localparam int P_W = A_W + B_W;

  logic signed [P_W-1:0] prod;
  logic signed [P_W-1:0] biased;
  logic [A_W-1:0]        frac_unused;

  // unsigned x signed: zero-extend the byte, then multiply as signed
  always_comb begin
    prod   = $signed({1'b0, a}) * $signed(b);
    biased = prod + P_W'(1 << (A_W - 1));
    {r, frac_unused} = biased;
  end
endmodule

// File: rtl/pbm_opsel.sv
module pbm_opsel
  import pbm_pkg::*;
#(
  parameter int A_W   = 8,
  parameter int B_W   = 16,
  parameter int NLANE = 4
) (
  input  logic [OP_W-1:0]             op,
  input  logic [NLANE*B_W-1:0]        src1,
  input  logic [NLANE*B_W-1:0]        src2,
  output logic [NLANE-1:0][A_W-1:0]   a_vec,
  output logic [NLANE-1:0][B_W-1:0]   b_vec
);
  localparam int NWIDE = NLANE / 2;

  for (genvar i = 0; i < NLANE; i++) begin : g_lane
    logic [A_W-1:0] byte_packed;
    logic [A_W-1:0] byte_hi;
    logic [A_W-1:0] byte_lo;
    logic [B_W-1:0] fac_lane;
    logic           wide_ok;

    assign byte_packed = src1[i*A_W +: A_W];
    assign byte_hi     = src1[i*B_W + A_W +: A_W];
    assign byte_lo     = src1[i*B_W +: A_W];
    assign fac_lane    = src2[i*B_W +: B_W];
    assign wide_ok     = (i < NWIDE);

    always_comb begin
      a_vec[i] = '0;
      b_vec[i] = '0;
      unique case (pbm_op_e'(op))
        OP_FULL:    begin a_vec[i] = byte_packed; b_vec[i] = fac_lane;          end
        OP_SCAL_HI: begin a_vec[i] = byte_packed; b_vec[i] = src2[2*B_W-1:B_W]; end
        OP_SCAL_LO: begin a_vec[i] = byte_packed; b_vec[i] = src2[B_W-1:0];     end
        OP_BSEL_HI: begin a_vec[i] = byte_hi;     b_vec[i] = fac_lane;          end
        OP_BSEL_LO: begin a_vec[i] = byte_lo;     b_vec[i] = fac_lane;          end
        OP_WIDE_HI: if (wide_ok) begin a_vec[i] = byte_hi; b_vec[i] = fac_lane; end
        OP_WIDE_LO: if (wide_ok) begin a_vec[i] = byte_lo; b_vec[i] = fac_lane; end
        default:    begin a_vec[i] = '0; b_vec[i] = '0; end
      endcase
    end
  end
endmodule

// File: rtl/pbm_pack.sv
module pbm_pack
  import pbm_pkg::*;
#(
  parameter int A_W   = 8,
  parameter int B_W   = 16,
  parameter int NLANE = 4
) (
  input  logic [OP_W-1:0]           op,
  input  logic [NLANE-1:0][B_W-1:0] res,
  output logic [NLANE*B_W-1:0]      data
);
  localparam int NWIDE  = NLANE / 2;
  localparam int SLOT_W = 2 * B_W;
  localparam int OFS    = A_W - 1;

  logic [NLANE*B_W-1:0] flat;
  logic [NLANE*B_W-1:0] wide;

  assign flat = res;

  for (genvar i = 0; i < NWIDE; i++) begin : g_wide
    assign wide[i*SLOT_W +: SLOT_W] =
      {{(SLOT_W-B_W-OFS){1'b0}}, res[i], {OFS{1'b0}}};
  end

  always_comb begin
    unique case (pbm_op_e'(op))
      OP_FULL, OP_SCAL_HI, OP_SCAL_LO,
      OP_BSEL_HI, OP_BSEL_LO:   data = flat;
      OP_WIDE_HI, OP_WIDE_LO:   data = wide;
      default:                  data = '0;
    endcase
  end
endmodule

// File: rtl/pbm_mul.sv
module pbm_mul
  import pbm_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [OP_W-1:0]   in_op,
  input  logic [DATA_W-1:0] in_src1,
  input  logic [DATA_W-1:0] in_src2,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [DATA_W-1:0] out_data
);
  logic [LANES-1:0][BYTE_W-1:0] a_vec;
  logic [LANES-1:0][HALF_W-1:0] b_vec;
  logic [LANES-1:0][HALF_W-1:0] res;
  logic [DATA_W-1:0]            packed_d;
  logic                         accept;

  pbm_opsel #(.A_W(BYTE_W), .B_W(HALF_W), .NLANE(LANES)) u_opsel (
    .op    (in_op),
    .src1  (in_src1),
    .src2  (in_src2),
    .a_vec (a_vec),
    .b_vec (b_vec)
  );

  for (genvar i = 0; i < LANES; i++) begin : g_mul
    pbm_lane #(.A_W(BYTE_W), .B_W(HALF_W)) u_lane (
      .a (a_vec[i]),
      .b (b_vec[i]),
      .r (res[i])
    );
  end

  pbm_pack #(.A_W(BYTE_W), .B_W(HALF_W), .NLANE(LANES)) u_pack (
    .op   (in_op),
    .res  (res),
    .data (packed_d)
  );

  assign in_ready = !out_valid || out_ready;
  assign accept   = in_valid && in_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_data  <= '0;
    end else begin
      if (in_ready) out_valid <= in_valid;
      if (accept)   out_data  <= packed_d;
    end
  end
endmodule

// File: rtl/pbm_mul_chk.sv
module pbm_mul_chk
  import pbm_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              in_valid,
  input logic              in_ready,
  input logic [OP_W-1:0]   in_op,
  input logic              out_valid,
  input logic              out_ready,
  input logic [DATA_W-1:0] out_data
);
  logic acc;
  assign acc = in_valid && in_ready;

  assert_accept_lands_R8: assert property (@(posedge clk) disable iff (!rst_n)
    acc |=> out_valid);

  assert_drain_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!acc && out_ready) |=> !out_valid);

  assert_stall_blocks_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |-> !in_ready);

  assert_stall_holds_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

  assert_reserved_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && in_op == OP_NONE) |=> (out_data == '0));

  assert_wide_zero_bits_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && (in_op == OP_WIDE_HI || in_op == OP_WIDE_LO)) |=>
      (out_data[6:0] == '0 && out_data[31:23] == '0 &&
       out_data[38:32] == '0 && out_data[63:55] == '0));
endmodule

bind pbm_mul pbm_mul_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_valid  (in_valid),
  .in_ready  (in_ready),
  .in_op     (in_op),
  .out_valid (out_valid),
  .out_ready (out_ready),
  .out_data  (out_data)
);

// File: tb/pbm_mul_bench.sv
`timescale 1ns/1ps
module pbm_mul_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [2:0]  in_op = 3'd0;
  logic [63:0] in_src1 = '0;
  logic [63:0] in_src2 = '0;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic [63:0] out_data;

  int nchk = 0;
  int nerr = 0;

  always #4 clk = ~clk;

  pbm_mul u_pbm_mul (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_op(in_op), .in_src1(in_src1), .in_src2(in_src2),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data)
  );

  function automatic logic [15:0] rnd(int a, logic [15:0] f);
    int p, q, half;
    p = a * int'($signed(f));
    q = p >>> 8;
    half = (p >>> 7) & 1;
    return 16'(q + half);
  endfunction

  function automatic logic [63:0] model(int op, logic [63:0] s1, logic [63:0] s2);
    logic [63:0] r = '0;
    for (int i = 0; i < 4; i++) begin
      case (op)
        0: r[16*i +: 16] = rnd(int'(s1[8*i +: 8]), s2[16*i +: 16]);
        1: r[16*i +: 16] = rnd(int'(s1[8*i +: 8]), s2[31:16]);
        2: r[16*i +: 16] = rnd(int'(s1[8*i +: 8]), s2[15:0]);
        3: r[16*i +: 16] = rnd(int'(s1[16*i+8 +: 8]), s2[16*i +: 16]);
        4: r[16*i +: 16] = rnd(int'(s1[16*i +: 8]), s2[16*i +: 16]);
        5: if (i < 2) r[32*i+7 +: 16] = rnd(int'(s1[16*i+8 +: 8]), s2[16*i +: 16]);
        6: if (i < 2) r[32*i+7 +: 16] = rnd(int'(s1[16*i +: 8]), s2[16*i +: 16]);
        default: ;
      endcase
    end
    return r;
  endfunction

  task automatic check(string tag, logic [63:0] act, logic [63:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic send(int op, logic [63:0] s1, logic [63:0] s2,
                      logic [63:0] exp, string tag);
    @(negedge clk);
    in_op = 3'(op); in_src1 = s1; in_src2 = s2; in_valid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
    check({tag, " R8 valid"}, {63'd0, out_valid}, 64'd1);
    check(tag, out_data, exp);
  endtask

  initial begin
    #(8 * 150000);
    nerr++;
    $display("FAIL watchdog R8 actual=hung expected=done");
    $display("CHECKS %0d ERRORS %0d", nchk, nerr);
    $finish;
  end

  initial begin
    logic [15:0] facs [4];
    facs[0] = 16'h8000; facs[1] = 16'h7FFF; facs[2] = 16'hFF80; facs[3] = 16'h0081;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R10: reset state
    check("R10 out_valid", {63'd0, out_valid}, 64'd0);
    check("R10 in_ready", {63'd0, in_ready}, 64'd1);

    // R1/R2 directed extremes and wrap
    send(0, 64'h0000_0000_FFFF_FFFF, 64'h8000_8000_8000_8000,
         {4{16'h8080}}, "R1 255*-32768");
    send(0, 64'h0000_0000_FFFF_FFFF, 64'h7FFF_7FFF_7FFF_7FFF,
         {4{16'h7F7F}}, "R1 255*32767");
    send(0, 64'h0000_0000_0101_0101, 64'hFF80_FF80_FF80_FF80,
         64'd0, "R2 wrap");

    // bit 7 set in every variant: 1 * 0x0080 rounds to 1
    send(0, 64'h0101_0101_0101_0101, {4{16'h0080}}, {4{16'h0001}}, "R3 round");
    send(1, 64'h0101_0101_0101_0101, {4{16'h0080}}, {4{16'h0001}}, "R4 hi round");
    send(2, 64'h0101_0101_0101_0101, {4{16'h0080}}, {4{16'h0001}}, "R4 lo round");
    send(3, 64'h0101_0101_0101_0101, {4{16'h0080}}, {4{16'h0001}}, "R5 hi round");
    send(4, 64'h0101_0101_0101_0101, {4{16'h0080}}, {4{16'h0001}}, "R5 lo round");
    send(5, 64'h0101_0101_0101_0101, {4{16'h0080}},
         64'h0000_0080_0000_0080, "R6 hi round");
    send(6, 64'h0101_0101_0101_0101, {4{16'h0080}},
         64'h0000_0080_0000_0080, "R6 lo round");
    send(7, 64'hFFFF_FFFF_FFFF_FFFF, 64'h7FFF_7FFF_7FFF_7FFF, 64'd0, "R7 zero");

    // R8: output drains after an idle cycle
    @(negedge clk);
    check("R8 drain", {63'd0, out_valid}, 64'd0);

    // sweep every opcode over all multiplicand values and factor mixes
    for (int op = 0; op < 8; op++) begin
      for (int a = 0; a < 256; a++) begin
        for (int k = 0; k < 4; k++) begin
          logic [7:0] b0, b1, b2, b3;
          logic [63:0] s1, s2;
          string tg;
          b0 = 8'(a); b1 = 8'(a) ^ 8'h5A; b2 = 8'(255 - a); b3 = 8'(a + 7);
          s1 = {b3 ^ 8'h3C, b2 + 8'd1, b1, b0 ^ 8'hA5, b3, b2, b1, b0};
          s2 = {facs[(k+3)%4] ^ 16'(a), facs[(k+2)%4],
                facs[(k+1)%4] + 16'(a), facs[k]};
          case (op)
            0: tg = "R3 sweep";
            1, 2: tg = "R4 sweep";
            3, 4: tg = "R5 sweep";
            5, 6: tg = "R6 sweep";
            default: tg = "R7 sweep";
          endcase
          send(op, s1, s2, model(op, s1, s2), tg);
        end
      end
    end

    // R9: back-pressure
    @(negedge clk);
    out_ready = 1'b0;
    in_op = 3'd0; in_src1 = 64'h0000_0000_0000_0002;
    in_src2 = 64'h0000_0000_0000_0100; in_valid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    in_src1 = 64'h0000_0000_0000_0003;
    check("R9 in_ready low", {63'd0, in_ready}, 64'd0);
    check("R9 held A", out_data, 64'h0000_0000_0000_0002);
    @(posedge clk);
    @(negedge clk);
    check("R9 still A", out_data, 64'h0000_0000_0000_0002);
    check("R9 valid held", {63'd0, out_valid}, 64'd1);
    out_ready = 1'b1;
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
    check("R9 B after release", out_data, 64'h0000_0000_0000_0003);
    @(posedge clk);
    @(negedge clk);
    check("R8 drain end", {63'd0, out_valid}, 64'd0);

    $display("CHECKS %0d ERRORS %0d", nchk, nerr);
    $finish;
  end
endmodule